// File: doc/BRIEF.md
# Page Permission and Reference/Change Update Unit

This unit sits after a page-table walker. It receives one leaf page-table entry together with the kind of access (load, store or instruction fetch), the privilege state of the requester and a per-context authority mask. From these inputs it decides whether the access may proceed and which permissions are granted. It also builds the fault report. A data-side fault produces a status word and a faulting address. A fetch-side fault produces an error code.

When the access is allowed, the unit marks the entry as referenced. On a store it also marks the entry as changed. It sends the updated entry to memory through a simple valid/ready write port, but only if the update altered the entry's value. On any load or fetch, the unit withholds write permission from the granted set. A later store to the same page therefore has to come back through the unit, which then sets the change bit. A single-cycle completion strobe closes every request. The strobe fires once the write-back handshake has finished, or one cycle after acceptance when no write-back is needed.

Top module: `pcru_top`

## Requirements
- R1: After reset, `rsp_done`, `wr_valid`, `rsp_fault` and `rsp_perm` are all 0, and `req_ready` is 1.
- R2: Entry field positions and encodings:
  - Bit 0 grants execute, bit 1 grants write and bit 2 grants read.
  - A set bit 1 also grants read.
  - `rsp_perm` reports the grants as {read, write, execute} in bits [2:0].
  - `req_amr` uses the same {read, write, execute} layout.
- R3: If bit 3 of the entry (privileged page) is set and `req_user` is 1, the granted set is empty, so every access faults.
- R4: If `req_user` is 1, or if bit 3 is set, the granted set is taken from the entry's authority bits alone, and `req_amr` has no effect.
- R5: If `req_user` is 0 and bit 3 is clear, the granted set is the entry's authority bitwise AND `req_amr`.
- R6: Access kinds are `req_kind` 0 = load, 1 = store, 2 = fetch. A load needs read, a store needs write and a fetch needs execute. If the needed grant is missing, the unit faults with cause 0x0800_0000.
- R7: When entry bits [5:4] equal 2'b11 (non-idempotent I/O) and the access is a fetch, the unit faults with cause 0x1000_0000, whatever the authority bits say.
- R8: On success, `rsp_pte` is the entry with bit 8 (referenced) set. Bit 7 (changed) is also set when the access is a store. On a fault, `rsp_perm` is 0 and no write-back happens.
- R9: On a successful load or fetch, the write grant is removed from `rsp_perm`.
- R10: The updated entry is driven on `wr_data`, with the request's entry address on `wr_addr`. This happens only if the entry differs from the original. `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_ready` is seen.
- R11: Data-side faults:
  - `rsp_status` is the cause, with 0x0200_0000 added on a store.
  - `rsp_addr` is `req_ea`.
  - `rsp_errcode` is 0.

  Fetch faults: `rsp_errcode` is the cause, and `rsp_status` and `rsp_addr` are 0. On success, all three are 0.
- R12: `rsp_done` is high for exactly one cycle. It rises one cycle after acceptance when no write-back is needed. Otherwise it rises one cycle after the cycle in which `wr_ready` met `wr_valid`.
- R13: A request is accepted only while `req_ready` is 1. A `req_valid` presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Requester in problem (user) state |
| req_amr | input | 3 | Authority mask {R,W,X} |
| req_pte | input | PTE_W | Leaf page-table entry |
| req_pte_addr | input | PA_W | Memory address of the entry |
| req_ea | input | EA_W | Effective address of the access |
| wr_valid | output | 1 | Entry write-back request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | PA_W | Write-back address |
| wr_data | output | PTE_W | Write-back data |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_fault | output | 1 | Access denied |
| rsp_perm | output | 3 | Granted set {R,W,X} |
| rsp_pte | output | PTE_W | Entry after reference/change update |
| rsp_status | output | 32 | Data-side fault status |
| rsp_addr | output | EA_W | Data-side faulting address |
| rsp_errcode | output | 32 | Fetch-side fault code |

## Verification
The permission decision is tried against several combinations of inputs:
- User and supervisor state, each on privileged and non-privileged pages. This separates the empty set, the mask-free path and the masked path.
- An authority mask that removes only write. This shows whether the mask is applied in the right case and ignored otherwise.
- Entries with reference and change already in different states. These tell a needed write-back from an unneeded one.
- Fetches on an I/O-typed entry with the execute grant set. These separate the guard cause from the protection cause.
- A stalled write port with a stray request during the stall. This shows that the port holds its data, that the strobe timing follows the handshake and that busy-time requests are dropped.

// File: rtl/pcru_pkg.sv
package pcru_pkg;
    localparam int CAUSE_W = 32;

    // entry field positions
    localparam int B_X    = 0;
    localparam int B_W    = 1;
    localparam int B_R    = 2;
    localparam int B_PRIV = 3;
    localparam int B_ATT0 = 4;
    localparam int B_CHG  = 7;
    localparam int B_REF  = 8;

    localparam logic [1:0] ATT_NIO = 2'b11;

    localparam logic [CAUSE_W-1:0] CAUSE_GUARD = 32'h1000_0000;
    localparam logic [CAUSE_W-1:0] CAUSE_PROT  = 32'h0800_0000;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 32'h0200_0000;

    // granted-set bit order {R,W,X}
    localparam int G_X = 0;
    localparam int G_W = 1;
    localparam int G_R = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } fsm_e;
endpackage

// File: rtl/pcru_perm_eval.sv
module pcru_perm_eval
    import pcru_pkg::*;
(
    input  logic [8:0]          pte_lo,
    input  acc_e                kind,
    input  logic                user,
    input  logic [2:0]          amr,
    output logic [2:0]          perm,
    output logic                fault,
    output logic [CAUSE_W-1:0]  cause
);
    logic [2:0] auth;
    logic [2:0] need;
    logic       guard;
    logic       priv;

    always_comb begin
        priv       = pte_lo[B_PRIV];
        auth[G_X]  = pte_lo[B_X];
        auth[G_W]  = pte_lo[B_W];
        auth[G_R]  = pte_lo[B_R] | pte_lo[B_W];

        guard = (pte_lo[B_ATT0+1:B_ATT0] == ATT_NIO) && (kind == ACC_FETCH);

        if (priv && user) begin
            perm = 3'b000;
        end else if (user || priv) begin
            perm = auth;
        end else begin
            perm = auth & amr;
        end

        unique case (kind)
            ACC_STORE: need = 3'b010;
            ACC_FETCH: need = 3'b001;
            default:   need = 3'b100;
        endcase

        fault = guard || ((need & ~perm) != 3'b000);
        if (guard) begin
            cause = CAUSE_GUARD;
        end else if (fault) begin
            cause = CAUSE_PROT;
        end else begin
            cause = '0;
        end
    end
endmodule

// File: rtl/pcru_rc_update.sv
module pcru_rc_update
    import pcru_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             is_store,
    input  logic [2:0]       perm_in,
    output logic [PTE_W-1:0] pte_out,
    output logic             changed,
    output logic [2:0]       perm_out
);
    always_comb begin
        pte_out        = pte_in;
        pte_out[B_REF] = 1'b1;
        perm_out       = perm_in;
        if (is_store) begin
            pte_out[B_CHG] = 1'b1;
        end else begin
            perm_out[G_W] = 1'b0;
        end
        changed = (pte_out != pte_in);
    end
endmodule

// File: rtl/pcru_fault_fmt.sv
module pcru_fault_fmt
    import pcru_pkg::*;
#(
    parameter int EA_W = 64
) (
    input  logic               fault,
    input  logic [CAUSE_W-1:0] cause,
    input  acc_e               kind,
    input  logic [EA_W-1:0]    ea,
    output logic [CAUSE_W-1:0] status,
    output logic [EA_W-1:0]    addr,
    output logic [CAUSE_W-1:0] errcode
);
    always_comb begin
        status  = '0;
        addr    = '0;
        errcode = '0;
        if (fault) begin
            if (kind == ACC_FETCH) begin
                errcode = cause;
            end else begin
                status = cause;
                if (kind == ACC_STORE) begin
                    status = status | CAUSE_STORE;
                end
                addr = ea;
            end
        end
    end
endmodule

// File: rtl/pcru_top.sv
module pcru_top
    import pcru_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int EA_W  = 64,
    parameter int PA_W  = 56
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [2:0]         req_amr,
    input  logic [PTE_W-1:0]   req_pte,
    input  logic [PA_W-1:0]    req_pte_addr,
    input  logic [EA_W-1:0]    req_ea,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [PA_W-1:0]    wr_addr,
    output logic [PTE_W-1:0]   wr_data,
    output logic               rsp_done,
    output logic               rsp_fault,
    output logic [2:0]         rsp_perm,
    output logic [PTE_W-1:0]   rsp_pte,
    output logic [31:0]        rsp_status,
    output logic [EA_W-1:0]    rsp_addr,
    output logic [31:0]        rsp_errcode
);
    typedef struct packed {
        fsm_e                st;
        acc_e                kind;
        logic                user;
        logic [PTE_W-1:0]    pte_org;
        logic [PTE_W-1:0]    pte_new;
        logic [PA_W-1:0]     pte_addr;
        logic [2:0]          perm;
        logic                fault;
        logic [CAUSE_W-1:0]  status;
        logic [EA_W-1:0]     addr;
        logic [CAUSE_W-1:0]  errcode;
    } state_t;

    state_t s_d, s_q;

    acc_e               kind_in;
    logic [2:0]         perm_raw;
    logic               fault_raw;
    logic [CAUSE_W-1:0] cause_raw;
    logic [PTE_W-1:0]   pte_upd;
    logic               pte_chg;
    logic [2:0]         perm_trim;
    logic [CAUSE_W-1:0] fmt_status;
    logic [EA_W-1:0]    fmt_addr;
    logic [CAUSE_W-1:0] fmt_errcode;

    assign kind_in = acc_e'(req_kind);

    pcru_perm_eval u_perm (
        .pte_lo (req_pte[8:0]),
        .kind   (kind_in),
        .user   (req_user),
        .amr    (req_amr),
        .perm   (perm_raw),
        .fault  (fault_raw),
        .cause  (cause_raw)
    );

    pcru_rc_update #(.PTE_W(PTE_W)) u_rc (
        .pte_in   (req_pte),
        .is_store (kind_in == ACC_STORE),
        .perm_in  (perm_raw),
        .pte_out  (pte_upd),
        .changed  (pte_chg),
        .perm_out (perm_trim)
    );

    pcru_fault_fmt #(.EA_W(EA_W)) u_fmt (
        .fault   (fault_raw),
        .cause   (cause_raw),
        .kind    (kind_in),
        .ea      (req_ea),
        .status  (fmt_status),
        .addr    (fmt_addr),
        .errcode (fmt_errcode)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.kind     = kind_in;
                    s_d.user     = req_user;
                    s_d.pte_org  = req_pte;
                    s_d.pte_addr = req_pte_addr;
                    s_d.fault    = fault_raw;
                    s_d.status   = fmt_status;
                    s_d.addr     = fmt_addr;
                    s_d.errcode  = fmt_errcode;
                    if (fault_raw) begin
                        s_d.perm    = 3'b000;
                        s_d.pte_new = req_pte;
                        s_d.st      = ST_DONE;
                    end else begin
                        s_d.perm    = perm_trim;
                        s_d.pte_new = pte_upd;
                        s_d.st      = pte_chg ? ST_WRITE : ST_DONE;
                    end
                end
            end
            ST_WRITE: begin
                if (wr_ready) begin
                    s_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, kind: ACC_LOAD, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign wr_valid    = (s_q.st == ST_WRITE);
    assign wr_addr     = s_q.pte_addr;
    assign wr_data     = s_q.pte_new;
    assign rsp_done    = (s_q.st == ST_DONE);
    assign rsp_fault   = s_q.fault;
    assign rsp_perm    = s_q.perm;
    assign rsp_pte     = s_q.pte_new;
    assign rsp_status  = s_q.status;
    assign rsp_addr    = s_q.addr;
    assign rsp_errcode = s_q.errcode;

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

    // R10
    wr_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data != s_q.pte_org));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R12
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> rsp_done);

    // R8
    wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[B_REF] && !rsp_fault));

    // R9
    rd_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && (s_q.kind != ACC_STORE)) |-> !rsp_perm[G_W]);

    // R3
    user_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && s_q.user && s_q.pte_org[B_PRIV]) |-> (rsp_fault && rsp_perm == 3'b000));

    // R13
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || rsp_done) |-> !req_ready);
endmodule

// File: tb/tb_pcru_top.sv
`timescale 1ns/1ps
module tb_pcru_top;
    localparam int PTE_W = 64;
    localparam int EA_W  = 64;
    localparam int PA_W  = 56;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_kind = 2'd0;
    logic             req_user = 1'b0;
    logic [2:0]       req_amr = 3'b111;
    logic [PTE_W-1:0] req_pte = '0;
    logic [PA_W-1:0]  req_pte_addr = '0;
    logic [EA_W-1:0]  req_ea = '0;
    logic             wr_valid;
    logic             wr_ready = 1'b0;
    logic [PA_W-1:0]  wr_addr;
    logic [PTE_W-1:0] wr_data;
    logic             rsp_done;
    logic             rsp_fault;
    logic [2:0]       rsp_perm;
    logic [PTE_W-1:0] rsp_pte;
    logic [31:0]      rsp_status;
    logic [EA_W-1:0]  rsp_addr;
    logic [31:0]      rsp_errcode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pcru_top #(.PTE_W(PTE_W), .EA_W(EA_W), .PA_W(PA_W)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected-result model written from the requirements
    task automatic run(input logic [1:0] kind, input logic user, input logic [2:0] amr,
                       input logic [63:0] pte, input int delay, input bit poke_busy);
        logic [2:0]  auth, perm, need;
        logic        guard, fault;
        logic [31:0] cause, e_status, e_err;
        logic [63:0] e_pte, e_addr;
        bit          e_wb, saw_wb, saw_done;
        logic [63:0] got_wdata;
        logic [PA_W-1:0] got_waddr;
        int          lat, wcnt;
        logic [PA_W-1:0] paddr;
        logic [63:0] ea;

        paddr = PA_W'(pte[15:0]) * 8 + 56'h1000;
        ea    = {pte[31:0], 32'hABCD_0000};
        auth  = {pte[2] | pte[1], pte[1], pte[0]};
        guard = (pte[5:4] == 2'b11) && (kind == 2'd2);
        if (pte[3] && user) perm = 3'b000;
        else if (user || pte[3]) perm = auth;
        else perm = auth & amr;
        need  = (kind == 2'd1) ? 3'b010 : (kind == 2'd2) ? 3'b001 : 3'b100;
        fault = guard || ((need & ~perm) != 0);
        cause = guard ? 32'h1000_0000 : 32'h0800_0000;
        e_status = '0; e_addr = '0; e_err = '0; e_pte = pte; e_wb = 1'b0;
        if (fault) begin
            perm = 3'b000;
            if (kind == 2'd2) e_err = cause;
            else begin
                e_status = cause | ((kind == 2'd1) ? 32'h0200_0000 : 32'h0);
                e_addr = ea;
            end
        end else begin
            e_pte = pte | 64'h100 | ((kind == 2'd1) ? 64'h80 : 64'h0);
            if (kind != 2'd1) perm[1] = 1'b0;
            e_wb = (e_pte != pte);
        end

        @(negedge clk);
        chk(req_ready == 1'b1, "R13 ready when idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_kind = kind; req_user = user; req_amr = amr;
        req_pte = pte; req_pte_addr = paddr; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
        req_pte = ~pte;
        lat = 1; wcnt = 0; saw_wb = 1'b0; saw_done = 1'b0;
        got_wdata = '0; got_waddr = '0;
        while (!saw_done && lat < 50) begin
            if (rsp_done) begin
                saw_done = 1'b1;
            end else begin
                if (wr_valid) begin
                    if (saw_wb) begin
                        chk(wr_data == got_wdata && wr_addr == got_waddr, "R10 hold during stall",
                            wr_data, got_wdata);
                    end
                    saw_wb = 1'b1; got_wdata = wr_data; got_waddr = wr_addr;
                    if (wcnt >= delay) begin
                        wr_ready = 1'b1;
                        req_valid = 1'b0;
                    end else begin
                        wr_ready = 1'b0;
                        if (poke_busy) begin
                            req_valid = 1'b1;
                            req_kind = 2'd2;
                        end
                    end
                    wcnt++;
                end
                @(negedge clk);
                wr_ready = 1'b0;
                req_valid = 1'b0;
                lat++;
            end
        end
        chk(saw_done, "R12 done seen", 64'(saw_done), 64'd1);
        chk(saw_wb == e_wb, "R10 write-back presence", 64'(saw_wb), 64'(e_wb));
        if (e_wb) begin
            chk(got_wdata == e_pte, "R8 write-back data", got_wdata, e_pte);
            chk(got_waddr == paddr, "R10 write-back address", 64'(got_waddr), 64'(paddr));
            chk(lat == delay + 2, "R12 latency after handshake", 64'(lat), 64'(delay + 2));
        end else begin
            chk(lat == 1, "R12 latency without write-back", 64'(lat), 64'd1);
        end
        chk(rsp_fault == fault, "R6 fault flag", 64'(rsp_fault), 64'(fault));
        chk(rsp_perm == perm, "R5 granted set", 64'(rsp_perm), 64'(perm));
        chk(rsp_pte == e_pte, "R8 updated entry", rsp_pte, e_pte);
        chk(rsp_status == e_status, "R11 status", 64'(rsp_status), 64'(e_status));
        chk(rsp_addr == e_addr, "R11 address", rsp_addr, e_addr);
        chk(rsp_errcode == e_err, "R11 errcode", 64'(rsp_errcode), 64'(e_err));
        @(negedge clk);
        chk(!rsp_done && !wr_valid, "R12 single strobe / R13 stray ignored",
            64'({rsp_done, wr_valid}), 64'd0);
    endtask

    task automatic t_reset();
        chk(!rsp_done && !wr_valid && !rsp_fault && rsp_perm == 0 && req_ready,
            "R1 reset state", 64'({rsp_done, wr_valid, rsp_fault, rsp_perm, req_ready}), 64'h1);
    endtask

    task automatic t_load_fresh();   run(2'd0, 1'b0, 3'b111, 64'h0000_0000_0000_0007, 0, 0); endtask // R9 R10
    task automatic t_load_ref_set(); run(2'd0, 1'b0, 3'b111, 64'h0000_0000_0000_0106, 0, 0); endtask // R10 no wb
    task automatic t_store_fresh();  run(2'd1, 1'b1, 3'b000, 64'h0000_0000_0000_0006, 1, 0); endtask // R4 R8
    task automatic t_store_clean();  run(2'd1, 1'b0, 3'b111, 64'h0000_0000_0000_0186, 0, 0); endtask // R10
    task automatic t_store_ref_only(); run(2'd1, 1'b0, 3'b111, 64'h0000_0000_0000_0106, 0, 0); endtask // R8
    task automatic t_user_priv();    run(2'd0, 1'b1, 3'b111, 64'h0000_0000_0000_000F, 0, 0); endtask // R3
    task automatic t_amr_mask();     run(2'd1, 1'b0, 3'b101, 64'h0000_0000_0000_0107, 0, 0); endtask // R5 R11
    task automatic t_amr_load_ok();  run(2'd0, 1'b0, 3'b100, 64'h0000_0000_0000_0007, 0, 0); endtask // R5
    task automatic t_priv_super();   run(2'd1, 1'b0, 3'b000, 64'h0000_0000_0000_000E, 0, 0); endtask // R4
    task automatic t_fetch_guard();  run(2'd2, 1'b0, 3'b111, 64'h0000_0000_0000_0135, 0, 0); endtask // R7
    task automatic t_fetch_noexec(); run(2'd2, 1'b1, 3'b111, 64'h0000_0000_0000_0106, 0, 0); endtask // R6 R11
    task automatic t_fetch_ok();     run(2'd2, 1'b1, 3'b111, 64'h0000_0000_0000_0013, 0, 0); endtask // R9
    task automatic t_w_implies_r();  run(2'd0, 1'b1, 3'b000, 64'h0000_0000_0000_0102, 0, 0); endtask // R2
    task automatic t_stall_busy();   run(2'd1, 1'b0, 3'b111, 64'h0000_0000_0000_0003, 3, 1); endtask // R10 R12 R13

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_fresh();
        t_load_ref_set();
        t_store_fresh();
        t_store_clean();
        t_store_ref_only();
        t_user_priv();
        t_amr_mask();
        t_amr_load_ok();
        t_priv_super();
        t_fetch_guard();
        t_fetch_noexec();
        t_fetch_ok();
        t_w_implies_r();
        t_stall_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired R12 actual=%h expected=%h", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule